// File: doc/BRIEF.md
# NOR Flash Block Programming Controller

This controller sits on the host side of a parallel NOR flash bus and writes a run of consecutive words into the device. Software, or another block, supplies a start address and a word count and pulses `start`. The words themselves arrive on a valid/ready stream. The controller first puts the device into its fast-program mode with a short key sequence. After that, each word costs only two write cycles: a program command and then the address/data cycle.

After each word is written, the controller reads the target location repeatedly. It compares the most significant data bit with the same bit of the word it wrote, and the word counts as finished once the two agree. It then reads the location once more and compares every bit. The address advances until the last word has been verified. In every case the controller leaves fast-program mode with a two-write exit sequence and pulses `done`. If a verify read disagrees, or the device does not finish a word within the allowed number of polls, the run stops early. The controller then raises `err` and reports the offending address.

All bus cycles come from one cycle engine. A write holds address and data stable with the write strobe low for `WE_CYC` clocks. A read holds the output enable low for `RD_CYC` clocks.

Top module: `norprog_ctrl`

## Requirements
- R1: A `start` with `word_cnt` equal to 0 produces no bus cycle. `done` pulses on the clock after the start and `err` stays low.
- R2: A run with a non-zero count begins with three writes, in this order: (address 0x555, data 0xAA), (0x2AA, 0x55), (0x555, 0x20). No program command comes before them.
- R3: Each word is programmed with two writes: data 0xA0 to address 0x555, then the word to its target address.
- R4: During a write, `fl_we_n` is low for exactly `WE_CYC` consecutive clocks and `fl_ce_n` is low. `fl_addr` and `fl_dout` do not change while the strobe is low. `fl_we_n` and `fl_oe_n` are never low together.
- R5: After the data write, the controller reads the target address. If bit DW-1 of the read differs from bit DW-1 of the written word, it reads again.
- R6: Once bit DW-1 agrees, exactly one further read of the target is made, and all DW bits are compared with the written word.
- R7: Words are written to base, base+1, … base+count-1, in the order they were received on the stream.
- R8: `s_ready` is high only while the controller waits for the next word, and no bus cycle runs at that time. Exactly one word is taken for each address that is programmed.
- R9: After the last word verifies, the controller writes 0x90 and then 0x00 to 0x555. `done` then pulses for one clock with `err` low.
- R10: On a full-word mismatch the run stops without taking more words and issues the R9 exit writes. `err` goes high with `err_addr` set to the failing address, and `err` holds until the next accepted start.
- R11: If `POLL_MAX` consecutive polls of one word all disagree, the run stops as in R10, with `err_addr` set to that word's address. No verify read is made for that word.
- R12: `busy` is high from the clock after an accepted start until `done`. A `start` pulse while `busy` is high has no effect.
- R13: Under reset, `fl_we_n`, `fl_oe_n` and `fl_ce_n` are high, and `busy`, `done`, `err` and `s_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while busy) |
| base_addr | input | AW | First target address |
| word_cnt | input | CW | Number of words to program |
| s_valid | input | 1 | Stream word present |
| s_data | input | DW | Stream word |
| s_ready | output | 1 | Controller takes the word this clock |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock end-of-run pulse |
| err | output | 1 | Last run aborted |
| err_addr | output | AW | Address that caused the abort |
| fl_addr | output | AW | Flash address bus |
| fl_dout | output | DW | Data driven to the flash |
| fl_dq_oe | output | 1 | Enable for the flash data drivers |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |
| fl_din | input | DW | Data read from the flash |

## Verification
The assertions assume the following about the inputs:
- `fl_din` has a meaning only in the final clock of a read.
- `s_data` does not change while `s_valid` is high and the word has not yet been taken.
- The device eventually either finishes a word or is abandoned through the poll limit.

The bench drives every input half a clock away from the sampling edge and holds `s_valid` until a handshake happens. Its device model shows the inverse of the written top bit while it is busy, follows the key and exit sequences, and records any write that breaks them.

// File: rtl/norprog_pkg.sv
package norprog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_BYPASS,
        ST_WAIT,
        ST_PCMD,
        ST_PDATA,
        ST_POLL,
        ST_VERIFY,
        ST_EXIT1,
        ST_EXIT2,
        ST_FIN
    } prog_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACT,
        PH_REC
    } bus_phase_e;

    localparam logic [11:0] KEY_ADDR_A = 12'h555;
    localparam logic [11:0] KEY_ADDR_B = 12'h2AA;
    localparam logic [7:0]  KEY_DATA_A = 8'hAA;
    localparam logic [7:0]  KEY_DATA_B = 8'h55;
    localparam logic [7:0]  CODE_FAST  = 8'h20;
    localparam logic [7:0]  CODE_PROG  = 8'hA0;
    localparam logic [7:0]  CODE_LEAVE = 8'h90;
    localparam logic [7:0]  CODE_ZERO  = 8'h00;

    typedef struct packed {
        logic [11:0] addr_lo;
        logic [7:0]  code;
    } fixed_cmd_t;

    // Address and code of the write issued in each fixed-command state.
    function automatic fixed_cmd_t cmd_for_state(prog_state_e s);
        fixed_cmd_t c;
        c.addr_lo = KEY_ADDR_A;
        c.code    = CODE_ZERO;
        case (s)
            ST_UNL1:   c.code = KEY_DATA_A;
            ST_UNL2:   begin c.addr_lo = KEY_ADDR_B; c.code = KEY_DATA_B; end
            ST_BYPASS: c.code = CODE_FAST;
            ST_PCMD:   c.code = CODE_PROG;
            ST_EXIT1:  c.code = CODE_LEAVE;
            default:   c.code = CODE_ZERO;
        endcase
        return c;
    endfunction

    // States in which a bus cycle is requested.
    function automatic logic is_bus_state(prog_state_e s);
        case (s)
            ST_UNL1, ST_UNL2, ST_BYPASS, ST_PCMD, ST_PDATA,
            ST_POLL, ST_VERIFY, ST_EXIT1, ST_EXIT2: return 1'b1;
            default:                                 return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/norprog_bus_cycle.sv
module norprog_bus_cycle
    import norprog_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int WE_CYC = 3,
    parameter int RD_CYC = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          req_wr,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          idle,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    output logic          fl_dq_oe,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    input  logic [DW-1:0] fl_din
);
    localparam int CMAX = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
    localparam int TW   = $clog2(CMAX + 1);

    bus_phase_e    phase;
    logic [TW-1:0] left;
    logic          wr_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            left    <= '0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rdata_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (req) begin
                    phase  <= PH_ACT;
                    wr_q   <= req_wr;
                    addr_q <= req_addr;
                    data_q <= req_data;
                    left   <= req_wr ? TW'(WE_CYC - 1) : TW'(RD_CYC - 1);
                end
                PH_ACT: begin
                    if (!wr_q && left == '0) rdata_q <= fl_din;
                    if (left == '0) phase <= PH_REC;
                    else            left  <= left - 1'b1;
                end
                PH_REC:  phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign idle     = (phase == PH_IDLE);
    assign ack      = (phase == PH_REC);
    assign rdata    = rdata_q;
    assign fl_addr  = addr_q;
    assign fl_dout  = data_q;
    assign fl_dq_oe = wr_q && (phase != PH_IDLE);
    assign fl_ce_n  = (phase == PH_IDLE);
    assign fl_we_n  = !(phase == PH_ACT && wr_q);
    assign fl_oe_n  = !(phase == PH_ACT && !wr_q);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(!fl_we_n && !fl_oe_n));                                  // R4
    AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> !fl_ce_n);                                    // R4
    AST_WE_HOLD_BUS: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout))); // R4

endmodule

// File: rtl/norprog_word_track.sv
module norprog_word_track #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] count,
    output logic [AW-1:0] addr,
    output logic          last
);
    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            remain <= '0;
        end else if (load) begin
            addr   <= base;
            remain <= count;
        end else if (step) begin
            addr   <= addr + 1'b1;
            remain <= remain - 1'b1;
        end
    end

    assign last = (remain == CW'(1));

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        step |-> (remain > CW'(1)));                               // R7

endmodule

// File: rtl/norprog_poll_timer.sv
module norprog_poll_timer #(
    parameter int POLL_MAX = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic miss,
    output logic last_try
);
    localparam int TW = $clog2(POLL_MAX + 1);

    logic [TW-1:0] fails;

    always_ff @(posedge clk) begin
        if (rst)       fails <= '0;
        else if (clr)  fails <= '0;
        else if (miss) fails <= fails + 1'b1;
    end

    assign last_try = (fails == TW'(POLL_MAX - 1));

    AST_POLL_BOUND: assert property (@(posedge clk) disable iff (rst)
        fails < TW'(POLL_MAX));                                    // R11

endmodule

// File: rtl/norprog_ctrl.sv
module norprog_ctrl
    import norprog_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter int CW       = 8,
    parameter int WE_CYC   = 3,
    parameter int RD_CYC   = 2,
    parameter int POLL_MAX = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] word_cnt,
    input  logic          s_valid,
    input  logic [DW-1:0] s_data,
    output logic          s_ready,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [AW-1:0] err_addr,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dout,
    output logic          fl_dq_oe,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    input  logic [DW-1:0] fl_din
);
    prog_state_e   state;
    logic [DW-1:0] word_q;
    logic          err_q;
    logic [AW-1:0] err_addr_q;

    logic          bus_req, bus_wr, bus_idle, bus_ack;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data, bus_rdata;
    fixed_cmd_t    fixed_cmd;

    logic [AW-1:0] cur_addr;
    logic          last_word, trk_load, trk_step;
    logic          poll_last, poll_clr, poll_miss;
    logic          top_match, full_match;

    assign top_match  = (bus_rdata[DW-1] == word_q[DW-1]);
    assign full_match = (bus_rdata == word_q);

    always_comb begin
        fixed_cmd = cmd_for_state(state);
        bus_req   = bus_idle && is_bus_state(state);
        bus_wr    = 1'b1;
        bus_addr  = AW'(fixed_cmd.addr_lo);
        bus_data  = DW'(fixed_cmd.code);
        case (state)
            ST_PDATA: begin
                bus_addr = cur_addr;
                bus_data = word_q;
            end
            ST_POLL, ST_VERIFY: begin
                bus_wr   = 1'b0;
                bus_addr = cur_addr;
                bus_data = '0;
            end
            default: ;
        endcase
    end

    assign trk_load  = (state == ST_IDLE) && start && (word_cnt != '0);
    assign trk_step  = (state == ST_VERIFY) && bus_ack && full_match && !last_word;
    assign poll_clr  = (state == ST_WAIT) && s_valid;
    assign poll_miss = (state == ST_POLL) && bus_ack && !top_match && !poll_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            word_q     <= '0;
            err_q      <= 1'b0;
            err_addr_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    err_q <= 1'b0;
                    state <= (word_cnt == '0) ? ST_FIN : ST_UNL1;
                end
                ST_UNL1:   if (bus_ack) state <= ST_UNL2;
                ST_UNL2:   if (bus_ack) state <= ST_BYPASS;
                ST_BYPASS: if (bus_ack) state <= ST_WAIT;
                ST_WAIT: if (s_valid) begin
                    word_q <= s_data;
                    state  <= ST_PCMD;
                end
                ST_PCMD:  if (bus_ack) state <= ST_PDATA;
                ST_PDATA: if (bus_ack) state <= ST_POLL;
                ST_POLL: if (bus_ack) begin
                    if (top_match) begin
                        state <= ST_VERIFY;
                    end else if (poll_last) begin
                        err_q      <= 1'b1;
                        err_addr_q <= cur_addr;
                        state      <= ST_EXIT1;
                    end
                end
                ST_VERIFY: if (bus_ack) begin
                    if (!full_match) begin
                        err_q      <= 1'b1;
                        err_addr_q <= cur_addr;
                        state      <= ST_EXIT1;
                    end else if (last_word) begin
                        state <= ST_EXIT1;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                ST_EXIT1: if (bus_ack) state <= ST_EXIT2;
                ST_EXIT2: if (bus_ack) state <= ST_FIN;
                ST_FIN:   state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign s_ready  = (state == ST_WAIT);
    assign busy     = (state != ST_IDLE) && (state != ST_FIN);
    assign done     = (state == ST_FIN);
    assign err      = err_q;
    assign err_addr = err_addr_q;

    norprog_bus_cycle #(
        .AW(AW), .DW(DW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC)
    ) u_bus (
        .clk(clk), .rst(rst),
        .req(bus_req), .req_wr(bus_wr), .req_addr(bus_addr), .req_data(bus_data),
        .idle(bus_idle), .ack(bus_ack), .rdata(bus_rdata),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dq_oe(fl_dq_oe),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_din(fl_din)
    );

    norprog_word_track #(.AW(AW), .CW(CW)) u_track (
        .clk(clk), .rst(rst), .load(trk_load), .step(trk_step),
        .base(base_addr), .count(word_cnt), .addr(cur_addr), .last(last_word)
    );

    norprog_poll_timer #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk(clk), .rst(rst), .clr(poll_clr), .miss(poll_miss), .last_try(poll_last)
    );

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                           // R9
    AST_READY_QUIET_BUS: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> fl_ce_n);                                      // R8
    AST_ERR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(err));                       // R10

endmodule

// File: tb/norprog_ctrl_tb.sv
module norprog_ctrl_tb;
    localparam int AW = 16, DW = 8, CW = 8;
    localparam int WE_CYC = 3, RD_CYC = 2, POLL_MAX = 8;
    localparam int BUSY_READS = 3;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0, s_valid = 1'b0;
    logic [AW-1:0] base_addr = '0;
    logic [CW-1:0] word_cnt = '0;
    logic [DW-1:0] s_data = '0;
    logic s_ready, busy, done, err, fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;
    logic [AW-1:0] err_addr, fl_addr;
    logic [DW-1:0] fl_dout, fl_din;

    always #4 clk = ~clk;

    norprog_ctrl #(.AW(AW), .DW(DW), .CW(CW), .WE_CYC(WE_CYC), .RD_CYC(RD_CYC),
                   .POLL_MAX(POLL_MAX)) u_dut (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr), .word_cnt(word_cnt),
        .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready), .busy(busy), .done(done),
        .err(err), .err_addr(err_addr), .fl_addr(fl_addr), .fl_dout(fl_dout),
        .fl_dq_oe(fl_dq_oe), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
        .fl_din(fl_din)
    );

    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    function automatic logic [7:0] dval(input logic [15:0] b, input int i);
        return 8'(int'(b[7:0]) * 7 + i * 29 + 3);
    endfunction

    // ---------------- device model ----------------
    typedef enum int {M_READ, M_U1, M_U2, M_BYP, M_A0, M_X90} mstate_e;
    mstate_e mstate = M_READ;
    logic [7:0] mem [256];
    int  mw_cnt = 0, mr_cnt = 0, proto_err = 0, busy_left = 0;
    bit  hang = 1'b0, prev_we = 1'b1, prev_oe = 1'b1, pbit = 1'b0;
    int  fault_mode = 0;
    logic [15:0] fault_addr = '0;

    always_comb begin
        if (!fl_oe_n && !fl_ce_n)
            fl_din = (busy_left > 0 || hang) ? {~pbit, 7'h00} : mem[fl_addr[7:0]];
        else
            fl_din = 8'h00;
    end

    always @(posedge clk) begin
        prev_we <= fl_we_n;
        prev_oe <= fl_oe_n;
        if (rst) begin
            mstate <= M_READ; busy_left <= 0; hang <= 1'b0;
            for (int k = 0; k < 256; k++) mem[k] <= 8'hFF;
        end else begin
            if (!prev_oe && fl_oe_n) begin
                mr_cnt <= mr_cnt + 1;
                if (busy_left > 0) busy_left <= busy_left - 1;
            end
            if (!prev_we && fl_we_n) begin
                mw_cnt <= mw_cnt + 1;
                case (mstate)
                    M_READ: if (fl_addr == 16'h555 && fl_dout == 8'hAA) mstate <= M_U1;
                            else proto_err <= proto_err + 1;
                    M_U1:   if (fl_addr == 16'h2AA && fl_dout == 8'h55) mstate <= M_U2;
                            else proto_err <= proto_err + 1;
                    M_U2:   if (fl_addr == 16'h555 && fl_dout == 8'h20) mstate <= M_BYP;
                            else proto_err <= proto_err + 1;
                    M_BYP: begin
                        if (busy_left > 0 || hang) begin
                            if (fl_dout == 8'h90) begin
                                busy_left <= 0; hang <= 1'b0; mstate <= M_X90;
                            end else proto_err <= proto_err + 1;
                        end else if (fl_addr == 16'h555 && fl_dout == 8'hA0) mstate <= M_A0;
                        else if (fl_dout == 8'h90) mstate <= M_X90;
                        else proto_err <= proto_err + 1;
                    end
                    M_A0: begin
                        busy_left <= BUSY_READS;
                        pbit      <= fl_dout[7];
                        hang      <= (fault_mode == 2) && (fl_addr == fault_addr);
                        mem[fl_addr[7:0]] <= ((fault_mode == 1) && (fl_addr == fault_addr))
                                             ? (fl_dout ^ 8'h01) : fl_dout;
                        mstate    <= M_BYP;
                    end
                    M_X90:  if (fl_dout == 8'h00) mstate <= M_READ;
                            else proto_err <= proto_err + 1;
                    default: proto_err <= proto_err + 1;
                endcase
            end
        end
    end

    // ---------------- bus and stream monitors ----------------
    int wlen = 0, width_bad = 0, viol = 0;
    logic [15:0] w_addr;
    logic [7:0]  w_data;
    always @(negedge clk) begin
        if (!rst) begin
            if (!fl_we_n) begin
                if (wlen == 0) begin w_addr = fl_addr; w_data = fl_dout; end
                else if (fl_addr != w_addr || fl_dout != w_data || fl_ce_n) width_bad++;
                wlen++;
            end else if (wlen > 0) begin
                if (wlen != WE_CYC) width_bad++;
                wlen = 0;
            end
            if (!fl_we_n && !fl_oe_n) width_bad++;
            if (s_ready && (!fl_ce_n || !busy)) viol++;
        end
    end

    bit feed_on = 1'b0, hs_pend = 1'b0;
    int feed_idx = 0, feed_cnt = 0, cur_gap = 0, gap_left = 0, hs_total = 0;
    logic [15:0] feed_base = '0;
    always @(negedge clk) begin
        if (!feed_on) begin
            s_valid = 1'b0; hs_pend = 1'b0;
        end else begin
            if (hs_pend) begin
                hs_pend = 1'b0; feed_idx++; hs_total++;
                s_valid = 1'b0; gap_left = cur_gap;
            end
            if (!s_valid) begin
                if (gap_left > 0) gap_left--;
                else if (feed_idx < feed_cnt) begin
                    s_valid = 1'b1; s_data = dval(feed_base, feed_idx);
                end
            end
            if (s_valid && s_ready) hs_pend = 1'b1;
        end
    end

    // ---------------- vector table ----------------
    typedef struct packed {
        logic [15:0] base;
        logic [7:0]  cnt;
        logic [3:0]  gap;
        logic [1:0]  fault;   // 0 none, 1 stored bit 0 flipped, 2 never finishes
        logic [7:0]  fidx;
        logic        exp_err;
        logic        poke;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0010, 8'd1, 4'd0, 2'd0, 8'd0, 1'b0, 1'b0},
        '{16'h0020, 8'd5, 4'd0, 2'd0, 8'd0, 1'b0, 1'b0},
        '{16'h0040, 8'd8, 4'd3, 2'd0, 8'd0, 1'b0, 1'b0},
        '{16'h0060, 8'd6, 4'd1, 2'd1, 8'd2, 1'b1, 1'b0},
        '{16'h0080, 8'd4, 4'd0, 2'd2, 8'd3, 1'b1, 1'b0},
        '{16'h00F0, 8'd4, 4'd2, 2'd0, 8'd0, 1'b0, 1'b0},
        '{16'h00A0, 8'd3, 4'd0, 2'd1, 8'd0, 1'b1, 1'b0},
        '{16'h0030, 8'd2, 4'd1, 2'd0, 8'd0, 1'b0, 1'b1}
    };

    task automatic run_vec(input vec_t v);
        int w0, r0, p0, v0, b0, h0, n, exp_w, exp_r, bad;
        bit got;
        w0 = mw_cnt; r0 = mr_cnt; p0 = proto_err; v0 = viol; b0 = width_bad; h0 = hs_total;
        fault_mode = int'(v.fault);
        fault_addr = v.base + 16'(v.fidx);
        feed_base = v.base; feed_cnt = int'(v.cnt); feed_idx = 0;
        cur_gap = int'(v.gap); gap_left = int'(v.gap);
        feed_on = 1'b1;
        @(negedge clk);
        base_addr = v.base; word_cnt = v.cnt; start = 1'b1;
        got = 1'b0; n = 0;
        while (!got && n < 20000) begin
            @(negedge clk);
            n++;
            start = v.poke && (n == 10);
            if (v.poke && n == 10) begin
                chk(busy == 1'b1, "R12 busy during run", int'(busy), 1);
                base_addr = 16'h00C0; word_cnt = 8'd1;
            end
            if (done) got = 1'b1;
        end
        start = 1'b0;
        feed_on = 1'b0;
        chk(got, "R9 done seen (run timeout)", int'(got), 1);
        repeat (2) @(negedge clk);
        exp_w = (v.fault != 0) ? int'(v.fidx) + 1 : int'(v.cnt);
        exp_r = (exp_w - ((v.fault != 0) ? 1 : 0)) * (BUSY_READS + 2)
              + ((v.fault == 1) ? BUSY_READS + 2 : 0)
              + ((v.fault == 2) ? POLL_MAX : 0);
        chk(err == v.exp_err, "R9/R10/R11 err flag", int'(err), int'(v.exp_err));
        if (v.exp_err)
            chk(err_addr == v.base + 16'(v.fidx), "R10/R11 err_addr",
                int'(err_addr), int'(v.base + 16'(v.fidx)));
        chk(mw_cnt - w0 == 5 + 2 * exp_w, "R2/R3/R9 write cycles", mw_cnt - w0, 5 + 2 * exp_w);
        chk(mr_cnt - r0 == exp_r, "R5/R6 read cycles", mr_cnt - r0, exp_r);
        chk(proto_err == p0, "R2/R3/R9 command order", proto_err - p0, 0);
        chk(mstate == M_READ, "R9 device left fast mode", int'(mstate), int'(M_READ));
        bad = 0;
        for (int i = 0; i < exp_w; i++)
            if (!(v.fault != 0 && i == int'(v.fidx)))
                if (mem[8'(int'(v.base[7:0]) + i)] != dval(v.base, i)) bad++;
        chk(bad == 0, "R7 stored words", bad, 0);
        chk(hs_total - h0 == exp_w, "R8 words taken", hs_total - h0, exp_w);
        chk(viol == v0, "R8 ready with bus idle", viol - v0, 0);
        chk(width_bad == b0, "R4 write strobe shape", width_bad - b0, 0);
        if (v.poke)
            chk(mem[8'hC0] == 8'hFF, "R12 start while busy ignored", int'(mem[8'hC0]), 255);
    endtask

    initial begin
        int w0;
        repeat (5) @(negedge clk);
        // R13 reset state
        chk(fl_we_n && fl_oe_n && fl_ce_n, "R13 strobes high in reset",
            int'({fl_we_n, fl_oe_n, fl_ce_n}), 7);
        chk(!busy && !done && !err && !s_ready, "R13 status low in reset",
            int'({busy, done, err, s_ready}), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R1 zero count
        w0 = mw_cnt;
        base_addr = 16'h0050; word_cnt = 8'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R1 done after zero count", int'(done), 1);
        repeat (3) @(negedge clk);
        chk(mw_cnt == w0 && fl_ce_n, "R1 no bus cycle", mw_cnt - w0, 0);
        chk(err == 1'b0, "R1 err low", int'(err), 0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R10 err held until next accepted start, then cleared
        run_vec(VECS[3]);
        repeat (5) @(negedge clk);
        chk(err == 1'b1, "R10 err held while idle", int'(err), 1);
        run_vec(VECS[0]);
        chk(err == 1'b0, "R10 err cleared by next start", int'(err), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule